// File: doc/BRIEF.md
# Self-Recovering Watchdog Supervisor

This block supervises a processor system. It combines supply-status sequencing with a watchdog timer that recovers the system without outside help. The supply and monitored-input comparisons come in as digital flags that have already been resolved:

- supply valid, with the hysteresis applied outside the block;
- input above the high threshold;
- input below the warning threshold;
- input below the reset threshold.

The processor strobes an asynchronous, active-low clear input. The block drives three outputs: a power-fail warning, and a system reset in both active-high and active-low form.

Power-up works as follows. Once the supply is valid and the input is above the high threshold, the warning releases and a power-on delay of one timeout period runs. After that delay the reset releases and the watchdog is armed. From then on, every falling edge of the clear input restarts the timer and releases the reset. If a full timeout passes without a clear, the reset asserts. It then changes polarity after every further timeout, which gives a square wave of twice the timeout period until a clear arrives.

If the input drops below the warning threshold, the warning asserts and latches until the input is back above the high threshold. If the input drops below the reset threshold, or the supply becomes invalid, the block forces everything active at once. Clears are then ignored until a fresh power-up sequence has completed. The timeout is the parameter `TIMEOUT_CYC`, counted in clock cycles. Its default is 100 ms at 125 MHz.

States and transitions of the controller:
- `WD_OFF`: supply invalid. It goes to `WD_ARM` when supply becomes valid.
- `WD_ARM`: waiting for the input. It goes to `WD_POR` when the input is above the high threshold and not below the reset threshold. Entering `WD_POR` restarts the timer.
- `WD_POR`: power-on delay. It goes to `WD_RUN` on timeout.
- `WD_RUN`: reset inactive. A clear keeps it in `WD_RUN` and restarts the timer. A timeout moves it to `WD_TRIP`.
- `WD_TRIP`: reset active. A clear or a timeout moves it to `WD_RUN`; a clear also restarts the timer.
- Overrides from any state: reset-threshold loss sends `WD_POR`, `WD_RUN` and `WD_TRIP` to `WD_ARM`. Supply loss sends any state to `WD_OFF`.

Top module: `selfheal_wdog`

## Requirements
- R1: While `sup_ok` is 0, `sys_rst`=1, `sys_rst_n`=0 and `pf_warn`=1 in the same cycle. The timer is halted.
- R2: The power-up sequence starts only when `sup_ok`=1 and `in_above_hi`=1 both hold. Either one alone keeps reset active. `pf_warn` goes to 0 on the first clock edge where both hold.
- R3: After the edge that enters the power-on delay, `sys_rst` stays 1 for exactly `TIMEOUT_CYC` cycles and then goes to 0.
- R4: Falling edges on `tclr_n` during the power-on delay change neither its length nor the outputs.
- R5: A falling edge on `tclr_n` in `WD_RUN` or `WD_TRIP` restarts the timer from zero and drives `sys_rst` to 0 after the third rising clock edge following the fall (two synchronizer flops plus one edge-detect register).
- R6: Clears repeated at intervals shorter than `TIMEOUT_CYC` keep `sys_rst` at 0 indefinitely.
- R7: If `TIMEOUT_CYC` cycles pass in `WD_RUN` with no clear, `sys_rst` goes to 1. After each further `TIMEOUT_CYC` cycles with no clear, it changes polarity.
- R8: With `tclr_n` held static at 1 or at 0, `sys_rst` is a continuous square wave with period 2×`TIMEOUT_CYC`.
- R9: `pf_warn` goes to 1 in the same cycle that `in_below_warn`=1. It stays 1 until a clock edge with `in_above_hi`=1, even after `in_below_warn` returns to 0.
- R10: `in_below_rst`=1 forces `sys_rst` and `pf_warn` to 1 in the same cycle and stops the timer. Clears are then ignored, and reset stays active until `in_above_hi`=1 starts a new power-on delay that completes.
- R11: `sys_rst_n` is always the complement of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low flop reset |
| tclr_n | input | 1 | Asynchronous timer clear, falling edge active |
| sup_ok | input | 1 | Supply-valid flag, hysteresis applied outside |
| in_above_hi | input | 1 | Monitored input is above the high threshold |
| in_below_warn | input | 1 | Monitored input is below the warning threshold |
| in_below_rst | input | 1 | Monitored input is below the reset threshold |
| pf_warn | output | 1 | Power-fail warning, active high |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The forcing paths for supply loss, brown-out and warning are combinational. The bench therefore checks them one time unit after changing the inputs at a falling clock edge, with no clock edge in between.

A clear is due after the third rising edge following the fall of `tclr_n`. Entering the power-on delay takes one edge from `WD_ARM`; from `WD_OFF` it takes two edges, one through `WD_ARM`. Each timeout boundary falls exactly `TIMEOUT_CYC` edges after the timer restart.

The bench advances by whole cycles from a known restart point. It samples on both sides of each boundary: at `TIMEOUT_CYC`-1 it expects the old value, and at `TIMEOUT_CYC` the new one.

// File: rtl/wds_pkg.sv
package wds_pkg;

    typedef enum logic [2:0] {
        WD_OFF,
        WD_ARM,
        WD_POR,
        WD_RUN,
        WD_TRIP
    } wd_state_t;

endpackage

// File: rtl/wds_clr_sync.sv
module wds_clr_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_async_n,
    output logic clr_stb
);
    localparam int SHW = SYNC_STAGES + 1;

    logic [SHW-1:0] sh;

    // Synchronizer chain plus one history flop for the edge detect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SHW-2:0], clr_async_n};
    end

    assign clr_stb = sh[SHW-1] & ~sh[SHW-2];

endmodule

// File: rtl/wds_timer.sv
module wds_timer #(
    parameter int TIMEOUT_CYC = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign tick = run & ~restart & (cnt == LAST);

endmodule

// File: rtl/wds_fsm.sv
module wds_fsm
    import wds_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sup_ok,
    input  logic      in_above_hi,
    input  logic      in_below_warn,
    input  logic      in_below_rst,
    input  logic      clr_stb,
    input  logic      tick,
    output wd_state_t state,
    output logic      tmr_run,
    output logic      tmr_restart,
    output logic      rst_act,
    output logic      warn_act
);
    wd_state_t nxt;
    logic      warn_q;
    logic      live;

    assign live = (state == WD_POR) || (state == WD_RUN) || (state == WD_TRIP);

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            WD_OFF:  if (sup_ok) nxt = WD_ARM;
            WD_ARM:  if (in_above_hi && !in_below_rst) nxt = WD_POR;
            WD_POR:  if (tick) nxt = WD_RUN;
            WD_RUN:  if (clr_stb) nxt = WD_RUN;
                     else if (tick) nxt = WD_TRIP;
            WD_TRIP: if (clr_stb || tick) nxt = WD_RUN;
            default: nxt = WD_OFF;
        endcase
        if (in_below_rst && live) nxt = WD_ARM;
        if (!sup_ok)              nxt = WD_OFF;
    end

    // State register and warning latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= WD_OFF;
            warn_q <= 1'b1;
        end else begin
            state <= nxt;
            if (!sup_ok || in_below_warn || in_below_rst) warn_q <= 1'b1;
            else if (in_above_hi)                         warn_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        tmr_run     = live && sup_ok && !in_below_rst;
        tmr_restart = ((state == WD_ARM) && (nxt == WD_POR)) ||
                      (((state == WD_RUN) || (state == WD_TRIP)) && clr_stb && (nxt == WD_RUN));
        rst_act     = (state != WD_RUN) || !sup_ok || in_below_rst;
        warn_act    = warn_q || !sup_ok || in_below_warn || in_below_rst;
    end

endmodule

// File: rtl/selfheal_wdog.sv
module selfheal_wdog
    import wds_pkg::*;
#(
    parameter int TIMEOUT_CYC = 12_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclr_n,
    input  logic sup_ok,
    input  logic in_above_hi,
    input  logic in_below_warn,
    input  logic in_below_rst,
    output logic pf_warn,
    output logic sys_rst,
    output logic sys_rst_n
);
    wd_state_t state;
    logic      clr_stb;
    logic      tick;
    logic      tmr_run;
    logic      tmr_restart;
    logic      rst_act;

    wds_clr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_async_n (tclr_n),
        .clr_stb     (clr_stb)
    );

    wds_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (tmr_restart),
        .tick    (tick)
    );

    wds_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sup_ok        (sup_ok),
        .in_above_hi   (in_above_hi),
        .in_below_warn (in_below_warn),
        .in_below_rst  (in_below_rst),
        .clr_stb       (clr_stb),
        .tick          (tick),
        .state         (state),
        .tmr_run       (tmr_run),
        .tmr_restart   (tmr_restart),
        .rst_act       (rst_act),
        .warn_act      (pf_warn)
    );

    assign sys_rst   = rst_act;
    assign sys_rst_n = ~rst_act;

endmodule

// File: rtl/selfheal_wdog_chk.sv
module selfheal_wdog_chk
    import wds_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sup_ok,
    input logic      in_above_hi,
    input logic      in_below_rst,
    input logic      pf_warn,
    input logic      sys_rst,
    input wd_state_t state,
    input logic      tick,
    input logic      clr_stb
);
    // R1
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> sys_rst);

    // R10
    brownout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_below_rst |=> sys_rst);

    // R9
    warn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && pf_warn && !in_above_hi) |=> pf_warn);

    // R7
    trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && tick && !clr_stb) |=> sys_rst);

    // R5
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == WD_RUN || state == WD_TRIP) && clr_stb && sup_ok && !in_below_rst)
        |=> (!sys_rst || !sup_ok || in_below_rst));

    // R4
    por_clr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_POR && !tick && sup_ok && !in_below_rst) |=> (state == WD_POR));

endmodule

bind selfheal_wdog selfheal_wdog_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sup_ok       (sup_ok),
    .in_above_hi  (in_above_hi),
    .in_below_rst (in_below_rst),
    .pf_warn      (pf_warn),
    .sys_rst      (sys_rst),
    .state        (state),
    .tick         (tick),
    .clr_stb      (clr_stb)
);

// File: tb/sim_selfheal_wdog.sv
`timescale 1ns/1ps
module sim_selfheal_wdog;
    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tclr_n = 1'b1;
    logic sup_ok = 1'b0;
    logic in_above_hi = 1'b0;
    logic in_below_warn = 1'b1;
    logic in_below_rst = 1'b1;
    logic pf_warn, sys_rst, sys_rst_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    selfheal_wdog #(.TIMEOUT_CYC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .tclr_n(tclr_n), .sup_ok(sup_ok),
        .in_above_hi(in_above_hi), .in_below_warn(in_below_warn),
        .in_below_rst(in_below_rst), .pf_warn(pf_warn),
        .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Every reset check also confirms the complement output (R11)
    task automatic chk_rst(input string req, input logic exp);
        chk(req, "sys_rst", sys_rst, exp);
        chk("R11", "sys_rst_n", sys_rst_n, ~exp);
    endtask

    task automatic pulse_clr();
        tclr_n = 1'b0;
        step(1);
        tclr_n = 1'b1;
        step(2);
    endtask

    // Called at the negedge before the edge that enters the power-on delay
    task automatic check_por(input string req, input bit with_clr);
        step(1);
        chk(req, "pf_warn at POR entry", pf_warn, 1'b0);
        chk_rst(req, 1'b1);
        if (with_clr) begin
            tclr_n = 1'b0;
            step(1);
            tclr_n = 1'b1;
            step(T - 2);
            chk_rst("R4", 1'b1);
        end else begin
            step(T - 1);
        end
        chk_rst("R3", 1'b1);
        step(1);
        chk_rst("R3", 1'b0);
    endtask

    task automatic t_reset();
        chk_rst("R1", 1'b1);
        chk("R1", "pf_warn in reset", pf_warn, 1'b1);
    endtask

    task automatic t_powerup();
        in_above_hi = 1'b1; in_below_warn = 1'b0; in_below_rst = 1'b0;
        step(4);
        chk_rst("R2", 1'b1);
        chk("R2", "pf_warn without supply", pf_warn, 1'b1);
        sup_ok = 1'b1;
        step(1);
        chk_rst("R2", 1'b1);
        check_por("R3", 1'b1);
    endtask

    // Now in WD_RUN with the timer at zero
    task automatic t_square_static_high();
        step(T - 1); chk_rst("R7", 1'b0);
        step(1);     chk_rst("R7", 1'b1);
        step(T - 1); chk_rst("R8", 1'b1);
        step(1);     chk_rst("R8", 1'b0);
        step(T);     chk_rst("R8", 1'b1);
    endtask

    task automatic t_clear_in_trip();
        pulse_clr();
        chk_rst("R5", 1'b0);
        step(T - 1); chk_rst("R5", 1'b0);
        step(1);     chk_rst("R7", 1'b1);
    endtask

    task automatic t_repeated_clears();
        pulse_clr();
        chk_rst("R5", 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(T - 4);
            chk_rst("R6", 1'b0);
            pulse_clr();
            chk_rst("R6", 1'b0);
        end
    endtask

    task automatic t_static_low();
        tclr_n = 1'b0;
        step(3);     chk_rst("R5", 1'b0);
        step(T - 1); chk_rst("R8", 1'b0);
        step(1);     chk_rst("R8", 1'b1);
        step(T);     chk_rst("R8", 1'b0);
        tclr_n = 1'b1;
        step(T);     chk_rst("R8", 1'b1);
    endtask

    task automatic t_warn();
        pulse_clr();
        in_above_hi = 1'b0; in_below_warn = 1'b1;
        #1 chk("R9", "pf_warn same cycle", pf_warn, 1'b1);
        step(1);
        chk("R9", "pf_warn held", pf_warn, 1'b1);
        in_below_warn = 1'b0;
        step(1);
        chk("R9", "pf_warn between thresholds", pf_warn, 1'b1);
        chk_rst("R9", 1'b0);
        in_above_hi = 1'b1;
        step(1);
        chk("R9", "pf_warn released", pf_warn, 1'b0);
    endtask

    task automatic t_brownout();
        pulse_clr();
        in_above_hi = 1'b0; in_below_warn = 1'b1; in_below_rst = 1'b1;
        #1;
        chk_rst("R10", 1'b1);
        chk("R10", "pf_warn on brownout", pf_warn, 1'b1);
        step(1);
        pulse_clr();
        chk_rst("R10", 1'b1);
        step(2 * T);
        chk_rst("R10", 1'b1);
        in_below_rst = 1'b0; in_below_warn = 1'b0;
        step(1);
        chk_rst("R10", 1'b1);
        in_above_hi = 1'b1;
        check_por("R10", 1'b0);
    endtask

    task automatic t_supply_loss();
        pulse_clr();
        sup_ok = 1'b0;
        #1;
        chk_rst("R1", 1'b1);
        chk("R1", "pf_warn on supply loss", pf_warn, 1'b1);
        step(5);
        chk_rst("R1", 1'b1);
        sup_ok = 1'b1;
        step(1);
        chk_rst("R2", 1'b1);
        check_por("R3", 1'b0);
    endtask

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_powerup();
        t_square_static_high();
        t_clear_in_trip();
        t_repeated_clears();
        t_static_low();
        t_warn();
        t_brownout();
        t_supply_loss();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule